// File: doc/BRIEF.md
# Programmable Skewed Clock Divider

This block produces the clock of one output bank from a fast tick clock, in which one tick is one skew time unit. The nominal output period is `N` ticks. A pair of three-level divide selects multiplies that period by one of nine ratios. A pair of three-level phase selects moves the output edges by a signed number of ticks. A bank-kind parameter picks one of three skew tables: normal, wide-skew or feedback. In the wide-skew table, two codes borrow the skew of two neighbouring normal banks. Their phase codes enter through peer ports.

Every bank uses the same timing base, a sync counter that wraps every `N*120` ticks. The divided clock is placed as a modulo offset inside its period, measured from that counter. All divided clocks therefore stay phase-related across banks. New select values are taken only when the sync counter wraps. Beside the clock, the block gives a one-tick marker at the start of every high phase.

Top module: `clk_skew_divider`

## Requirements
- R1: Each three-level code is 2 bits: LOW=2'b00, MID=2'b01, HIGH=2'b10. With index i = 3*code(hi)+code(lo), the divide selects give ratios 1,2,3,4,5,6,8,10,12 for i = 0..8. The output period is N times the ratio, in ticks.
- R2: In a normal bank, phase-select index i = 3*code(hi)+code(lo) gives a skew of i-4 ticks, covering -4 to +4.
- R3: In a wide-skew bank, indices 0,1,2 give -8,-7,-6 ticks and indices 6,7,8 give +6,+7,+8. Index 4 gives 0. Index 3 takes the normal-table skew of peer A's code, and index 5 takes that of peer B's code. Each peer port is packed {hi code, lo code}.
- R4: In a feedback bank only the low phase select counts: LOW gives -4, MID gives 0, HIGH gives +4 ticks. The high phase select has no effect.
- R5: Code 2'b11 on any three-level input, peer codes included, acts exactly as MID.
- R6: For period P, the output is high for ceil(P/2) ticks and then low for the rest of the period.
- R7: Let t count clock edges from the release of reset, starting at 0. Then the output registered at edge t+1 is high when ((t - s) mod P) < ceil(P/2). A positive skew s delays the clock.
- R8: While reset is high, both outputs are low. With zero skew, the output goes high at the first edge after reset is released.
- R9: Select values are taken while reset is high, and then only on the edge where the sync counter wraps. The sync counter wraps every N*120 ticks, first at t = N*120-1. A change made between wraps has no effect before the next wrap.
- R10: rise_mark is high for one tick, in exactly the cycles where the phase position ((t - s) mod P) of R7 is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Tick clock, one tick per time unit |
| rst | input | 1 | Synchronous active-high reset |
| div_sel_hi | input | 2 | Upper three-level divide select |
| div_sel_lo | input | 2 | Lower three-level divide select |
| ph_sel_hi | input | 2 | Upper three-level phase select (ignored in a feedback bank) |
| ph_sel_lo | input | 2 | Lower three-level phase select |
| peer_a_ph | input | 4 | Phase codes {hi,lo} of the first normal bank, used by a wide-skew bank |
| peer_b_ph | input | 4 | Phase codes {hi,lo} of the second normal bank, used by a wide-skew bank |
| clk_out | output | 1 | Divided, skewed clock, registered |
| rise_mark | output | 1 | One-tick marker at the start of each high phase |

## Verification
The checks assume that `N` is at least 8, so every skew magnitude fits within one divided period. They also assume that the selects stay steady on the last reset edge, because the reset-release check on the loaded period allows a change only after reset or a wrap. The stimulus applies each configuration before reset is raised. It holds that configuration for the whole reset and run, and changes selects in mid-run only in the test that targets the wrap rule.

// File: rtl/ckd_pkg.sv
package ckd_pkg;

  localparam int BANK_NORMAL   = 0;
  localparam int BANK_WIDE     = 1;
  localparam int BANK_FEEDBACK = 2;

  // every ratio divides this, so all banks realign at the sync wrap
  localparam int SYNC_MULT = 120;

  typedef logic [3:0]        div_t;
  typedef logic signed [4:0] skew_t;

  // three-level code to 0/1/2, 2'b11 folded to MID
  function automatic logic [1:0] tri_level(input logic [1:0] code);
    return (code == 2'b11) ? 2'b01 : code;
  endfunction

  function automatic logic [3:0] pair_index(input logic [1:0] hi, input logic [1:0] lo);
    return 4'(tri_level(hi)) * 4'd3 + 4'(tri_level(lo));
  endfunction

  function automatic div_t ratio_of(input logic [3:0] idx);
    div_t r;
    case (idx)
      4'd0, 4'd1, 4'd2, 4'd3, 4'd4, 4'd5: r = idx + 4'd1;
      4'd6:    r = 4'd8;
      4'd7:    r = 4'd10;
      default: r = 4'd12;
    endcase
    return r;
  endfunction

  function automatic skew_t normal_skew(input logic [3:0] idx);
    return skew_t'({1'b0, idx}) - skew_t'(4);
  endfunction

  function automatic skew_t wide_skew(input logic [3:0] idx, input skew_t from_a,
                                      input skew_t from_b);
    skew_t s;
    case (idx)
      4'd0:    s = skew_t'(-8);
      4'd1:    s = skew_t'(-7);
      4'd2:    s = skew_t'(-6);
      4'd3:    s = from_a;
      4'd5:    s = from_b;
      4'd6:    s = skew_t'(6);
      4'd7:    s = skew_t'(7);
      4'd8:    s = skew_t'(8);
      default: s = skew_t'(0);
    endcase
    return s;
  endfunction

  function automatic skew_t feedback_skew(input logic [1:0] code);
    skew_t s;
    case (tri_level(code))
      2'b00:   s = skew_t'(-4);
      2'b10:   s = skew_t'(4);
      default: s = skew_t'(0);
    endcase
    return s;
  endfunction

endpackage

// File: rtl/ckd_sel_decode.sv
module ckd_sel_decode
  import ckd_pkg::*;
#(
  parameter int BANK_KIND = BANK_NORMAL
) (
  input  logic [1:0] ds_hi,
  input  logic [1:0] ds_lo,
  input  logic [1:0] f_hi,
  input  logic [1:0] f_lo,
  input  logic [3:0] peer_a,
  input  logic [3:0] peer_b,
  output div_t       div_ratio,
  output skew_t      skew
);

  logic [3:0] f_idx;
  skew_t      skew_a;
  skew_t      skew_b;

  always_comb begin
    div_ratio = ratio_of(pair_index(ds_hi, ds_lo));
    f_idx     = pair_index(f_hi, f_lo);
    skew_a    = normal_skew(pair_index(peer_a[3:2], peer_a[1:0]));
    skew_b    = normal_skew(pair_index(peer_b[3:2], peer_b[1:0]));
    if (BANK_KIND == BANK_WIDE) begin
      skew = wide_skew(f_idx, skew_a, skew_b);
    end else if (BANK_KIND == BANK_FEEDBACK) begin
      skew = feedback_skew(f_lo);
    end else begin
      skew = normal_skew(f_idx);
    end
  end

endmodule

// File: rtl/ckd_sync_counter.sv
module ckd_sync_counter
  import ckd_pkg::*;
#(
  parameter int N = 8
) (
  input  logic clk,
  input  logic rst,
  output logic wrap
);

  localparam int CW  = N * SYNC_MULT;
  localparam int CWW = $clog2(CW);
  localparam logic [CWW-1:0] LAST = CWW'(CW - 1);
  localparam logic [CWW-1:0] ONE  = CWW'(1);

  logic [CWW-1:0] cnt;

  assign wrap = (cnt == LAST);

  always_ff @(posedge clk) begin
    if (rst || wrap) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + ONE;
    end
  end

endmodule

// File: rtl/ckd_phase_gen.sv
module ckd_phase_gen
  import ckd_pkg::*;
#(
  parameter int N  = 8,
  parameter int PW = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wrap,
  input  div_t          new_div,
  input  skew_t         new_skew,
  output logic [PW-1:0] pos,
  output logic [PW-1:0] act_period
);

  localparam logic [PW-1:0] ONE = PW'(1);

  logic [PW-1:0] next_period;
  logic [PW-1:0] next_init;
  logic [4:0]    mag;
  logic [PW-1:0] mag_w;

  // starting phase position = (-skew) mod period
  always_comb begin
    next_period = PW'(N * int'(new_div));
    mag         = new_skew[4] ? 5'(-new_skew) : 5'(new_skew);
    mag_w       = PW'(mag);
    if (new_skew[4]) begin
      next_init = (mag_w >= next_period) ? mag_w - next_period : mag_w;
    end else if (mag == 5'd0) begin
      next_init = '0;
    end else begin
      next_init = next_period - mag_w;
    end
  end

  always_ff @(posedge clk) begin
    if (rst || wrap) begin
      act_period <= next_period;
      pos        <= next_init;
    end else if (pos == act_period - ONE) begin
      pos <= '0;
    end else begin
      pos <= pos + ONE;
    end
  end

endmodule

// File: rtl/ckd_out_stage.sv
module ckd_out_stage #(
  parameter int PW = 7
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [PW-1:0] pos,
  input  logic [PW-1:0] act_period,
  output logic          clk_out,
  output logic          rise_mark
);

  logic [PW:0]   half_sum;
  logic [PW-1:0] hi_len;

  always_comb begin
    half_sum = {1'b0, act_period} + (PW+1)'(1);
    hi_len   = half_sum[PW:1];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      clk_out   <= 1'b0;
      rise_mark <= 1'b0;
    end else begin
      clk_out   <= (pos < hi_len);
      rise_mark <= (pos == '0);
    end
  end

endmodule

// File: rtl/clk_skew_divider.sv
module clk_skew_divider
  import ckd_pkg::*;
#(
  parameter int N         = 8,
  parameter int BANK_KIND = BANK_NORMAL
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] div_sel_hi,
  input  logic [1:0] div_sel_lo,
  input  logic [1:0] ph_sel_hi,
  input  logic [1:0] ph_sel_lo,
  input  logic [3:0] peer_a_ph,
  input  logic [3:0] peer_b_ph,
  output logic       clk_out,
  output logic       rise_mark
);

  localparam int PW = $clog2(N * 12 + 1);

  div_t          new_div;
  skew_t         new_skew;
  logic          sync_wrap;
  logic [PW-1:0] pos;
  logic [PW-1:0] act_period;

  ckd_sel_decode #(.BANK_KIND(BANK_KIND)) u_dec (
    .ds_hi     (div_sel_hi),
    .ds_lo     (div_sel_lo),
    .f_hi      (ph_sel_hi),
    .f_lo      (ph_sel_lo),
    .peer_a    (peer_a_ph),
    .peer_b    (peer_b_ph),
    .div_ratio (new_div),
    .skew      (new_skew)
  );

  ckd_sync_counter #(.N(N)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .wrap (sync_wrap)
  );

  ckd_phase_gen #(.N(N), .PW(PW)) u_phase (
    .clk        (clk),
    .rst        (rst),
    .wrap       (sync_wrap),
    .new_div    (new_div),
    .new_skew   (new_skew),
    .pos        (pos),
    .act_period (act_period)
  );

  ckd_out_stage #(.PW(PW)) u_out (
    .clk        (clk),
    .rst        (rst),
    .pos        (pos),
    .act_period (act_period),
    .clk_out    (clk_out),
    .rise_mark  (rise_mark)
  );

endmodule

// File: rtl/ckd_checker.sv
module ckd_checker #(
  parameter int N  = 8,
  parameter int PW = 7
) (
  input logic          clk,
  input logic          rst,
  input logic          clk_out,
  input logic          rise_mark,
  input logic          sync_wrap,
  input logic [PW-1:0] pos,
  input logic [PW-1:0] act_period
);

  logic legal_period;

  always_comb begin
    legal_period = 1'b0;
    for (int r = 1; r <= 12; r++) begin
      if (r != 7 && r != 9 && r != 11 && act_period == PW'(N * r)) legal_period = 1'b1;
    end
  end

  // R1: loaded period is N times one of the nine ratios
  a_r1_period_legal: assert property (@(posedge clk) disable iff (rst) legal_period);

  // R7: phase position stays inside the loaded period
  a_r7_pos_in_period: assert property (@(posedge clk) disable iff (rst) pos < act_period);

  // R8: outputs are quiet after a reset edge
  a_r8_reset_quiet: assert property (@(posedge clk) rst |=> (!clk_out && !rise_mark));

  // R9: loaded period changes only after reset or a sync wrap
  a_r9_load_at_wrap: assert property (@(posedge clk) disable iff (rst)
    !$stable(act_period) |-> ($past(sync_wrap) || $past(rst)));

  // R10: marker only appears while the clock is high
  a_r10_mark_in_high: assert property (@(posedge clk) disable iff (rst) rise_mark |-> clk_out);

endmodule

bind clk_skew_divider ckd_checker #(.N(N), .PW(PW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .clk_out    (clk_out),
  .rise_mark  (rise_mark),
  .sync_wrap  (sync_wrap),
  .pos        (pos),
  .act_period (act_period)
);

// File: tb/tb_clk_skew_divider.sv
module tb_clk_skew_divider;

  localparam int CLK_PERIOD = 10;
  localparam int N  = 8;
  localparam int CW = N * 120;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [1:0] ds1 = 2'b00, ds0 = 2'b00, f1 = 2'b01, f0 = 2'b01;
  logic [3:0] pa = 4'b0000, pb = 4'b1001;
  logic       o_n, m_n, o_w, m_w, o_f, m_f;

  int checks = 0;
  int failures = 0;
  string cur_tag = "";
  int perA[3];
  int skA[3];
  int perB[3];
  int skB[3];

  always #(CLK_PERIOD/2) clk = ~clk;

  clk_skew_divider #(.N(N), .BANK_KIND(0)) dut (
    .clk(clk), .rst(rst), .div_sel_hi(ds1), .div_sel_lo(ds0), .ph_sel_hi(f1), .ph_sel_lo(f0),
    .peer_a_ph(pa), .peer_b_ph(pb), .clk_out(o_n), .rise_mark(m_n));
  clk_skew_divider #(.N(N), .BANK_KIND(1)) dut_wide (
    .clk(clk), .rst(rst), .div_sel_hi(ds1), .div_sel_lo(ds0), .ph_sel_hi(f1), .ph_sel_lo(f0),
    .peer_a_ph(pa), .peer_b_ph(pb), .clk_out(o_w), .rise_mark(m_w));
  clk_skew_divider #(.N(N), .BANK_KIND(2)) dut_fb (
    .clk(clk), .rst(rst), .div_sel_hi(ds1), .div_sel_lo(ds0), .ph_sel_hi(f1), .ph_sel_lo(f0),
    .peer_a_ph(pa), .peer_b_ph(pb), .clk_out(o_f), .rise_mark(m_f));

  function automatic int tv(input logic [1:0] c);
    return (c == 2'b11) ? 1 : int'(c);
  endfunction

  function automatic logic [1:0] tc(input int i);
    return (i == 0) ? 2'b00 : (i == 1) ? 2'b01 : 2'b10;
  endfunction

  function automatic int ratio(input logic [1:0] a, input logic [1:0] b);
    int i = 3 * tv(a) + tv(b);
    return (i < 6) ? i + 1 : 8 + 2 * (i - 6);
  endfunction

  function automatic int skn(input logic [1:0] a, input logic [1:0] b);
    return 3 * tv(a) + tv(b) - 4;
  endfunction

  function automatic int skw(input logic [1:0] a, input logic [1:0] b);
    int i = 3 * tv(a) + tv(b);
    if (i < 3) return i - 8;
    if (i == 3) return skn(pa[3:2], pa[1:0]);
    if (i == 4) return 0;
    if (i == 5) return skn(pb[3:2], pb[1:0]);
    return i;
  endfunction

  function automatic int skf(input logic [1:0] b);
    return (tv(b) - 1) * 4;
  endfunction

  function automatic int phase_pos(input int t, input int p, input int s);
    return (((t - s) % p) + p) % p;
  endfunction

  task automatic snap(input bit to_b);
    for (int j = 0; j < 3; j++) begin
      if (to_b) perB[j] = N * ratio(ds1, ds0); else perA[j] = N * ratio(ds1, ds0);
    end
    if (to_b) begin
      skB[0] = skn(f1, f0); skB[1] = skw(f1, f0); skB[2] = skf(f0);
    end else begin
      skA[0] = skn(f1, f0); skA[1] = skw(f1, f0); skA[2] = skf(f0);
    end
  endtask

  task automatic check(input logic act, input logic exp, input string tag, input int t);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s t=%0d actual=%0b expected=%0b", tag, cur_tag, t, act, exp);
    end
  endtask

  task automatic start_cfg();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    check(o_n, 1'b0, "R8 reset clk_out normal", -1);
    check(m_n, 1'b0, "R8 reset mark normal", -1);
    check(o_w, 1'b0, "R8 reset clk_out wide", -1);
    check(o_f, 1'b0, "R8 reset clk_out feedback", -1);
    snap(1'b0);
    snap(1'b1);
    rst = 1'b0;
  endtask

  task automatic run_span(input int from_t, input int to_t);
    for (int k = from_t; k < to_t; k++) begin
      @(negedge clk);
      for (int j = 0; j < 3; j++) begin
        int p = (k < CW) ? perA[j] : perB[j];
        int s = (k < CW) ? skA[j] : skB[j];
        int ph = phase_pos(k, p, s);
        logic eo = (ph < (p + 1) / 2);
        logic em = (ph == 0);
        case (j)
          0: begin
            check(o_n, eo, "R1 R2 R6 R7 R8 clk_out normal", k);
            check(m_n, em, "R10 mark normal", k);
          end
          1: begin
            check(o_w, eo, "R3 R6 R7 clk_out wide", k);
            check(m_w, em, "R10 mark wide", k);
          end
          default: begin
            check(o_f, eo, "R4 R6 R7 clk_out feedback", k);
            check(m_f, em, "R10 mark feedback", k);
          end
        endcase
      end
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    failures++;
    checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    // full sweep of divide and phase codes, all bank kinds
    cur_tag = "sweep";
    for (int d = 0; d < 9; d++) begin
      for (int f = 0; f < 9; f++) begin
        @(negedge clk);
        ds1 = tc(d / 3); ds0 = tc(d % 3);
        f1 = tc(f / 3);  f0 = tc(f % 3);
        start_cfg();
        run_span(0, 2 * N * ratio(ds1, ds0) + 2);
      end
    end

    // R5: illegal code 2'b11 everywhere acts as MID
    cur_tag = "R5 illegal code";
    @(negedge clk);
    ds1 = 2'b11; ds0 = 2'b00; f1 = 2'b11; f0 = 2'b11; pa = 4'b1111; pb = 4'b1110;
    start_cfg();
    run_span(0, 2 * N * 4 + 2);
    @(negedge clk);
    ds1 = 2'b00; ds0 = 2'b11; f1 = 2'b11; f0 = 2'b00;
    start_cfg();
    run_span(0, 2 * N * 2 + 2);

    // R3: wide bank borrows peer skews
    cur_tag = "R3 peer copy";
    @(negedge clk);
    pa = 4'b1010; pb = 4'b0001; ds1 = 2'b00; ds0 = 2'b00;
    f1 = 2'b01; f0 = 2'b00;
    start_cfg();
    run_span(0, 2 * N + 2);
    @(negedge clk);
    f0 = 2'b10;
    start_cfg();
    run_span(0, 2 * N + 2);

    // R9: mid-run change waits for the sync wrap
    cur_tag = "R9 wrap load";
    @(negedge clk);
    ds1 = 2'b00; ds0 = 2'b00; f1 = 2'b01; f0 = 2'b01;
    start_cfg();
    run_span(0, 100);
    ds1 = 2'b00; ds0 = 2'b10; f1 = 2'b10; f0 = 2'b10;
    snap(1'b1);
    run_span(100, CW + 2 * N * 3 + 4);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule